// File: doc/BRIEF.md
# USART Bit-Rate Clock Generator

This block makes the bit timing for a serial transmitter and receiver. A 12-bit down-counter, clocked by the system clock, reloads from a programmed divisor and emits a one-cycle prescale tick every divisor+1 cycles. In the asynchronous modes a post-divider turns these ticks into a transmit bit enable every 16 ticks, or every 8 ticks at double speed. Every tick is also passed to the receiver as its oversampling enable, together with a flag that says whether 16 or 8 samples make up one bit.

In synchronous master mode a two-state clock-level machine (states `LVL_LO` and `LVL_HI`) toggles on every tick, which gives one bit every 2×(divisor+1) cycles. Transition `LVL_LO -> LVL_HI` is the rising edge and `LVL_HI -> LVL_LO` is the falling edge. A polarity input decides which edge makes the transmit enable, and the other edge makes the receive enable. In synchronous slave mode the same edges come from an external clock pin instead. The pin passes through a synchronizer and an edge detector, and the enable follows a pin change after two system clocks.

Mode encoding on `mode_i`: 0 = asynchronous, 1 = synchronous master, 2 = synchronous slave, 3 = asynchronous. Writing the divisor restarts the prescaler and all post-division state at once.

Top module: `usart_rate_gen`

## Requirements
- R1: With divisor D (0..4095), prescale ticks come every D+1 system cycles. The first tick comes D+1 cycles after the cycle in which `div_wr_i` is high, and no tick occurs in the write cycle itself. With D=0 there is a tick every cycle.
- R2: In asynchronous mode with `dbl_speed_i`=0, `rx_en_o` pulses on every tick and `tx_en_o` pulses on the 16th tick after a write and on every 16th tick after that. This gives a bit rate of fclk/(16(D+1)).
- R3: In asynchronous mode with `dbl_speed_i`=1, `tx_en_o` pulses on every 8th tick, for a bit rate of fclk/(8(D+1)). `rx_os8_o` is 1 in this mode.
- R4: In synchronous master mode the clock level starts in `LVL_LO` after a write and toggles on each tick. With `clk_pol_i`=0 the rising transition gives `tx_en_o` and the falling transition gives `rx_en_o`. The bit period is 2(D+1) cycles.
- R5: `dbl_speed_i` has no effect in either synchronous mode: the enables are unchanged and `rx_os8_o` is 0.
- R6: With `clk_pol_i`=1 the roles swap: the falling transition gives `tx_en_o` and the rising transition gives `rx_en_o`.
- R7: In synchronous slave mode, a pin change first present during cycle c produces a one-cycle enable in cycle c+2. A rising pin edge counts as the rising transition and a falling pin edge as the falling transition, both under the polarity rule of R4 and R6.
- R8: A divisor write restarts counting at once. No tick left over from the old count appears after the write.
- R9: While `rst_n` is low, `tx_en_o` and `rx_en_o` are 0.
- R10: In synchronous modes `tx_en_o` and `rx_en_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode (0 async, 1 sync master, 2 sync slave, 3 async) |
| dbl_speed_i | input | 1 | Double-speed select, asynchronous mode only |
| clk_pol_i | input | 1 | Edge polarity for synchronous modes |
| div_wr_i | input | 1 | Divisor write strobe, restarts the counter |
| div_i | input | 12 | Divisor value |
| ext_clk_i | input | 1 | External clock pin for slave mode |
| tx_en_o | output | 1 | Transmit bit enable, one cycle |
| rx_en_o | output | 1 | Receive sample enable, one cycle |
| rx_os8_o | output | 1 | Receiver uses 8 samples per bit |

## Verification
A prescaler count that is off by one moves every later enable, so the error shows at the first pulse, D+1 cycles after a write. A post-divider phase error or a clock-level state stuck in `LVL_LO` or `LVL_HI` shows within one bit period as a missing, extra or swapped enable. A fault in the synchronizer depth moves the first slave enable off cycle c+2. The scoreboard predicts the exact cycle of every pulse for each mode, so any of these faults shows up as a mismatch inside the first window.

// File: rtl/usart_rate_pkg.sv
package usart_rate_pkg;
    typedef enum logic [1:0] {
        MODE_ASYNC     = 2'd0,
        MODE_SYNC_MST  = 2'd1,
        MODE_SYNC_SLV  = 2'd2,
        MODE_ASYNC_ALT = 2'd3
    } op_mode_e;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } clk_lvl_e;
endpackage

// File: rtl/rate_prescaler.sv
module rate_prescaler #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load_i)       cnt_q <= div_i;
        else if (cnt_q == '0)  cnt_q <= div_i;
        else                   cnt_q <= cnt_q - 1'b1;
    end

    always_comb tick_o = rst_n && (cnt_q == '0) && !load_i;

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

    // R8
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == $past(div_i));
endmodule

// File: rtl/async_postdiv.sv
module async_postdiv #(
    parameter int NORM_RATIO = 16,
    parameter int DBL_RATIO  = 8,
    localparam int PH_W = $clog2(NORM_RATIO)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    input  logic dbl_i,
    output logic tx_en_o
);
    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] last_ph;
    logic            wrap;

    always_comb begin
        last_ph = dbl_i ? PH_W'(DBL_RATIO - 1) : PH_W'(NORM_RATIO - 1);
        wrap    = (ph_q >= last_ph);
        tx_en_o = tick_i && wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ph_q <= '0;
        else if (clear_i) ph_q <= '0;
        else if (tick_i)  ph_q <= wrap ? '0 : ph_q + 1'b1;
    end

    // R2
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_o && !clear_i) |=> ph_q == '0);
endmodule

// File: rtl/sync_edge_unit.sv
module sync_edge_unit
    import usart_rate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic slave_i,
    input  logic clear_i,
    input  logic tick_i,
    input  logic pol_i,
    input  logic pin_i,
    output logic tx_en_o,
    output logic rx_en_o
);
    clk_lvl_e lvl_q, lvl_d;
    logic     meta_q, sync_q, prev_q;
    logic     rise, fall;

    always_comb begin
        lvl_d = lvl_q;
        unique case (lvl_q)
            LVL_LO: if (tick_i) lvl_d = LVL_HI;
            LVL_HI: if (tick_i) lvl_d = LVL_LO;
        endcase
        if (clear_i) lvl_d = LVL_LO;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= LVL_LO;
        else        lvl_q <= lvl_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        if (slave_i) begin
            rise = sync_q && !prev_q;
            fall = !sync_q && prev_q;
        end else begin
            rise = tick_i && (lvl_q == LVL_LO);
            fall = tick_i && (lvl_q == LVL_HI);
        end
        tx_en_o = pol_i ? fall : rise;
        rx_en_o = pol_i ? rise : fall;
    end

    // R4
    lvl_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_i && tick_i && !clear_i) |=> lvl_q != $past(lvl_q));

    // R7
    pin_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_i && (tx_en_o || rx_en_o)) |-> $past(meta_q) != $past(sync_q));

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_en_o && rx_en_o));
endmodule

// File: rtl/usart_rate_gen.sv
module usart_rate_gen
    import usart_rate_pkg::*;
#(
    parameter int DIV_W      = 12,
    parameter int NORM_RATIO = 16,
    parameter int DBL_RATIO  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             dbl_speed_i,
    input  logic             clk_pol_i,
    input  logic             div_wr_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             ext_clk_i,
    output logic             tx_en_o,
    output logic             rx_en_o,
    output logic             rx_os8_o
);
    op_mode_e mode;
    logic     is_sync, is_slave;
    logic     tick, a_tx, s_tx, s_rx;

    always_comb begin
        mode     = op_mode_e'(mode_i);
        is_slave = (mode == MODE_SYNC_SLV);
        is_sync  = is_slave || (mode == MODE_SYNC_MST);
    end

    rate_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .load_i(div_wr_i), .div_i(div_i), .tick_o(tick)
    );

    async_postdiv #(.NORM_RATIO(NORM_RATIO), .DBL_RATIO(DBL_RATIO)) u_adiv (
        .clk(clk), .rst_n(rst_n), .clear_i(div_wr_i), .tick_i(tick),
        .dbl_i(dbl_speed_i), .tx_en_o(a_tx)
    );

    sync_edge_unit u_sync (
        .clk(clk), .rst_n(rst_n), .slave_i(is_slave), .clear_i(div_wr_i),
        .tick_i(tick), .pol_i(clk_pol_i), .pin_i(ext_clk_i),
        .tx_en_o(s_tx), .rx_en_o(s_rx)
    );

    always_comb begin
        tx_en_o  = is_sync ? s_tx : a_tx;
        rx_en_o  = is_sync ? s_rx : tick;
        rx_os8_o = !is_sync && dbl_speed_i;
    end

    // R2
    async_tx_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_sync && tx_en_o) |-> rx_en_o);

    // R8
    wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_wr_i && !is_slave) |-> !(tx_en_o || rx_en_o));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> !(tx_en_o || rx_en_o));
endmodule

// File: tb/sim_usart_rate_gen.sv
module sim_usart_rate_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic        dbl_speed_i = 1'b0;
    logic        clk_pol_i = 1'b0;
    logic        div_wr_i = 1'b0;
    logic [11:0] div_i = '0;
    logic        ext_clk_i = 1'b0;
    logic        tx_en_o, rx_en_o, rx_os8_o;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";
    int exp_tx[$];
    int exp_rx[$];

    usart_rate_gen u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dbl_speed_i(dbl_speed_i),
        .clk_pol_i(clk_pol_i), .div_wr_i(div_wr_i), .div_i(div_i),
        .ext_clk_i(ext_clk_i), .tx_en_o(tx_en_o), .rx_en_o(rx_en_o),
        .rx_os8_o(rx_os8_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_bit(input string req, input logic act, input logic exp_v);
        n_run++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp_v, cyc);
        end
    endtask

    task automatic cmp_stream(input logic v, ref int q[$], input string nm);
        while (q.size() > 0 && q[0] < cyc) begin
            n_run++; n_fail++;
            $display("FAIL %s: %s pulse missing, actual none expected cycle %0d", cur_req, nm, q[0]);
            void'(q.pop_front());
        end
        if (v) begin
            n_run++;
            if (q.size() > 0 && q[0] == cyc) void'(q.pop_front());
            else begin
                n_fail++;
                $display("FAIL %s: %s pulse actual cycle %0d expected cycle %0d", cur_req, nm, cyc,
                         (q.size() > 0) ? q[0] : -1);
            end
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (mon_on) begin
            cmp_stream(tx_en_o, exp_tx, "tx");
            cmp_stream(rx_en_o, exp_rx, "rx");
        end
    end

    task automatic flush_left();
        mon_on = 1'b0;
        while (exp_tx.size() > 0) begin
            n_run++; n_fail++;
            $display("FAIL %s: tx pulse missing, actual none expected cycle %0d", cur_req, exp_tx[0]);
            void'(exp_tx.pop_front());
        end
        while (exp_rx.size() > 0) begin
            n_run++; n_fail++;
            $display("FAIL %s: rx pulse missing, actual none expected cycle %0d", cur_req, exp_rx[0]);
            void'(exp_rx.pop_front());
        end
    endtask

    // driver: program a mode and divisor, predict every pulse in the window
    task automatic prog(input string req, input logic [1:0] m, input logic dbl,
                        input logic pol, input int d, input int nwin);
        int w;
        @(posedge clk); #1;
        w = cyc;
        cur_req = req;
        mode_i = m; dbl_speed_i = dbl; clk_pol_i = pol;
        div_i = 12'(d); div_wr_i = 1'b1;
        exp_tx.delete(); exp_rx.delete();
        for (int j = 0; w + 1 + d + j * (d + 1) < w + nwin; j++) begin
            int t;
            t = w + 1 + d + j * (d + 1);
            if (m == 2'd1) begin
                if (((j % 2) == 0) == (pol == 1'b0)) exp_tx.push_back(t);
                else exp_rx.push_back(t);
            end else begin
                exp_rx.push_back(t);
                if ((j % (dbl ? 8 : 16)) == (dbl ? 7 : 15)) exp_tx.push_back(t);
            end
        end
        mon_on = 1'b1;
        @(posedge clk); #1;
        div_wr_i = 1'b0;
        repeat (nwin - 1) @(posedge clk);
        #1;
        flush_left();
    endtask

    task automatic prog_slave(input string req, input logic pol, input logic dbl);
        int w;
        int nwin;
        nwin = 34;
        @(posedge clk); #1;
        w = cyc;
        cur_req = req;
        mode_i = 2'd2; dbl_speed_i = dbl; clk_pol_i = pol;
        exp_tx.delete(); exp_rx.delete();
        for (int k = 0; k < 6; k++) begin
            if (((k % 2) == 0) == (pol == 1'b0)) exp_tx.push_back(w + 2 + 5 * k + 2);
            else exp_rx.push_back(w + 2 + 5 * k + 2);
        end
        mon_on = 1'b1;
        #1 check_bit({req, " rx_os8 in slave"}, rx_os8_o, 1'b0);
        for (int i = 1; i < nwin; i++) begin
            @(posedge clk); #1;
            if (i >= 2 && i <= 27 && ((i - 2) % 5) == 0) ext_clk_i = ~ext_clk_i;
        end
        @(posedge clk); #1;
        flush_left();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset holds the enables low
        check_bit("R9 tx in reset", tx_en_o, 1'b0);
        check_bit("R9 rx in reset", rx_en_o, 1'b0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        prog("R2", 2'd0, 1'b0, 1'b0, 2, 100);
        check_bit("R2 rx_os8 normal", rx_os8_o, 1'b0);
        prog("R3", 2'd0, 1'b1, 1'b0, 0, 20);
        check_bit("R3 rx_os8 double", rx_os8_o, 1'b1);
        prog("R1", 2'd3, 1'b1, 1'b0, 1, 40);
        prog("R4", 2'd1, 1'b0, 1'b0, 3, 40);
        prog("R5", 2'd1, 1'b1, 1'b0, 3, 40);
        check_bit("R5 rx_os8 master", rx_os8_o, 1'b0);
        prog("R6", 2'd1, 1'b0, 1'b1, 1, 30);
        prog("R8", 2'd0, 1'b0, 1'b0, 9, 5);
        prog("R8", 2'd0, 1'b1, 1'b0, 1, 40);
        prog_slave("R7", 1'b0, 1'b0);
        prog_slave("R6", 1'b1, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule